// File: doc/BRIEF.md
# Self-Programming Command Register

This block is the control and status register that sequences program-memory self-programming. Software arms a command by writing the enable bit, together with at most one command bit, through a plain register write port. The command bits select page erase, page write, lock-bit set or read-section re-enable. If only the enable bit is written, the armed command is a page-buffer load. A store-program strobe that arrives within a short window after the write issues the armed command. If no strobe arrives in that window, the armed bits clear again.

The block drives one-cycle command pulses to the flash array, with the captured page address or buffer word. It keeps a busy flag for the read-while-write section and asks the CPU to halt while the no-read-while-write section is being erased or written. A load-program strobe that follows an armed lock-set returns the lock bits or the fuse bits. A flash-done input ends every operation that has been issued. The flash array, page buffer and fuse storage stay outside the block. All pins are plain control and status signals. No pin carries a stream, so no back-pressure applies.

Top module: `selfprog_ctl`

## Requirements
- R1: The register reads as: bit 0 enable, bit 1 erase, bit 2 write, bit 3 lock-set, bit 4 re-enable, bit 6 section-busy. Bits 5 and 7 always read 0. The reset value is 0x00.
- R2: A write with bit 0 set and at most one of bits 1..4 set arms a command. A store strobe in any of the ARM_WIN (4) cycles after the write cycle issues it. If no strobe arrives, bits 0..4 read 0 from the cycle after the last window cycle, and a later strobe issues nothing.
- R3: A write with bit 0 clear leaves bits 0..4 at 0. A write with two or more of bits 1..4 set is ignored. After either write, a store strobe issues nothing.
- R4: An issued erase (0x03) or write (0x05) pulses `cmd_erase` or `cmd_write` for one cycle, starting the cycle after the strobe. `page_addr` holds Z[ZW-1:PAGE_BITS]. Bit 0 and the command bit stay set until the cycle after `flash_done`, when bits 0..4 read 0.
- R5: An erase or write to a page below NRWW_FIRST_PAGE sets the section-busy flag. An erase or write to a page at or above it asserts `halt_req` instead, from the cycle after the strobe until the cycle after `flash_done`.
- R6: An issued lock-set (0x09) pulses `cmd_lock` for one cycle, with `lock_wdata` equal to R0.
- R7: A load strobe in the first RD_WIN (3) cycles after a lock-set is armed raises `rd_valid` for one cycle, starting the next cycle. `rd_data` is the lock bits when Z bit 0 is 0 and the fuse bits when it is 1. A load strobe in a later cycle returns nothing.
- R8: An issued re-enable (0x11) clears the section-busy flag and bits 0 and 4 in the next cycle, and issues no pulse.
- R9: When only the enable bit (0x01) is armed, a strobe pulses `cmd_load` with `load_addr`=Z and `load_data`={R1,R0}. It clears the section-busy flag and keeps bit 0 set until `flash_done`.
- R10: While an issued operation awaits `flash_done`, register writes are ignored, so a re-enable cannot take effect.
- R11: An accepted write that arms re-enable while `buf_filling` is high pulses `buf_abort` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| st_strobe | input | 1 | Store-program instruction strobe |
| ld_strobe | input | 1 | Load-program instruction strobe |
| zptr | input | ZW | Z pointer |
| r0 | input | 8 | Low data register |
| r1 | input | 8 | High data register |
| flash_done | input | 1 | Flash operation finished |
| buf_filling | input | 1 | Page buffer load in progress |
| lock_bits | input | 8 | Current lock bits |
| fuse_bits | input | 8 | Current fuse bits |
| cmd_erase | output | 1 | Page erase pulse |
| cmd_write | output | 1 | Page write pulse |
| cmd_lock | output | 1 | Lock-bit set pulse |
| cmd_load | output | 1 | Page-buffer load pulse |
| page_addr | output | ZW-PAGE_BITS | Captured page address |
| load_addr | output | ZW | Captured buffer word address |
| load_data | output | 16 | Captured buffer word |
| lock_wdata | output | 8 | Captured lock value |
| rww_blocked | output | 1 | Read-while-write section busy |
| halt_req | output | 1 | CPU halt request |
| buf_abort | output | 1 | Page buffer load abort pulse |
| rd_valid | output | 1 | Lock/fuse read data valid |
| rd_data | output | 8 | Lock/fuse read data |

## Verification
The bench builds the block with its default parameters: a 16-bit Z pointer, 7 offset bits, a no-read-while-write region from page 448, a 4-cycle arm window and a 3-cycle read window. The small windows let random strobe delays of 1 to 6 cycles land on both sides of each window edge. The high region boundary lets a random Z pointer with forced top bits reach both sections in roughly equal numbers.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  localparam int B_EN  = 0;
  localparam int B_ERS = 1;
  localparam int B_WR  = 2;
  localparam int B_LCK = 3;
  localparam int B_RRE = 4;
  localparam int B_BSY = 6;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_ERASE,
    OP_WRITE,
    OP_LOCK,
    OP_REEN
  } sp_op_e;

  typedef struct packed {
    logic rre;
    logic lck;
    logic wr;
    logic ers;
  } sp_cmd_t;
endpackage

// File: rtl/sp_arm_window.sv
module sp_arm_window #(
  parameter int ARM_WIN = 4,
  parameter int RD_WIN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic active,
  output logic last,
  output logic rd_open
);
  localparam int CW = $clog2(ARM_WIN + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(ARM_WIN);
  localparam logic [CW-1:0] RD_FLOOR = CW'(ARM_WIN - RD_WIN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= CNT_FULL;
    else if (stop)        cnt_q <= '0;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active  = (cnt_q != '0);
  assign last    = (cnt_q == CW'(1));
  assign rd_open = (cnt_q > RD_FLOOR);
endmodule

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
  import selfprog_pkg::*;
(
  input  logic    en,
  input  sp_cmd_t cmd,
  output sp_op_e  op
);
  always_comb begin
    op = OP_NONE;
    if (en) begin
      if (cmd.ers)      op = OP_ERASE;
      else if (cmd.wr)  op = OP_WRITE;
      else if (cmd.lck) op = OP_LOCK;
      else if (cmd.rre) op = OP_REEN;
      else              op = OP_LOAD;
    end
  end
endmodule

// File: rtl/sp_fuse_read.sv
module sp_fuse_read (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       sel_fuse,
  input  logic [7:0] lock_bits,
  input  logic [7:0] fuse_bits,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take;
      if (take) rd_data <= sel_fuse ? fuse_bits : lock_bits;
    end
  end
endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
  import selfprog_pkg::*;
#(
  parameter int ZW              = 16,
  parameter int PAGE_BITS       = 7,
  parameter int NRWW_FIRST_PAGE = 448,
  parameter int ARM_WIN         = 4,
  parameter int RD_WIN          = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csr_we,
  input  logic [7:0]              csr_wdata,
  output logic [7:0]              csr_rdata,
  input  logic                    st_strobe,
  input  logic                    ld_strobe,
  input  logic [ZW-1:0]           zptr,
  input  logic [7:0]              r0,
  input  logic [7:0]              r1,
  input  logic                    flash_done,
  input  logic                    buf_filling,
  input  logic [7:0]              lock_bits,
  input  logic [7:0]              fuse_bits,
  output logic                    cmd_erase,
  output logic                    cmd_write,
  output logic                    cmd_lock,
  output logic                    cmd_load,
  output logic [ZW-PAGE_BITS-1:0] page_addr,
  output logic [ZW-1:0]           load_addr,
  output logic [15:0]             load_data,
  output logic [7:0]              lock_wdata,
  output logic                    rww_blocked,
  output logic                    halt_req,
  output logic                    buf_abort,
  output logic                    rd_valid,
  output logic [7:0]              rd_data
);
  localparam int PW = ZW - PAGE_BITS;
  localparam logic [PW-1:0] NRWW_PG = PW'(NRWW_FIRST_PAGE);

  logic    en_q, op_busy_q, rww_q, halt_q;
  sp_cmd_t cmd_q, cmd_w;
  sp_op_e  op;
  logic    win_active, win_last, win_rd_open;
  logic    fire, wr_ok, expire, rd_take;
  logic [PW-1:0] z_page;
  logic    z_nrww;

  assign cmd_w  = sp_cmd_t'(csr_wdata[B_RRE:B_ERS]);
  assign z_page = zptr[ZW-1:PAGE_BITS];
  assign z_nrww = (z_page >= NRWW_PG);

  assign fire   = st_strobe && en_q && !op_busy_q && win_active;
  assign wr_ok  = csr_we && !op_busy_q && !fire &&
                  ($countones(csr_wdata[B_RRE:B_ERS]) <= 1);
  assign expire = win_last && en_q && !op_busy_q && !fire && !wr_ok;
  assign rd_take = ld_strobe && en_q && cmd_q.lck && !op_busy_q && win_rd_open;

  sp_arm_window #(.ARM_WIN(ARM_WIN), .RD_WIN(RD_WIN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_ok && csr_wdata[B_EN]),
    .stop    (fire || (wr_ok && !csr_wdata[B_EN])),
    .active  (win_active),
    .last    (win_last),
    .rd_open (win_rd_open)
  );

  sp_cmd_decode u_dec (
    .en  (en_q),
    .cmd (cmd_q),
    .op  (op)
  );

  sp_fuse_read u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (rd_take),
    .sel_fuse  (zptr[0]),
    .lock_bits (lock_bits),
    .fuse_bits (fuse_bits),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // Armed state, section busy and halt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      cmd_q     <= '0;
      op_busy_q <= 1'b0;
      rww_q     <= 1'b0;
      halt_q    <= 1'b0;
    end else if (op_busy_q) begin
      if (flash_done) begin
        en_q      <= 1'b0;
        cmd_q     <= '0;
        op_busy_q <= 1'b0;
        halt_q    <= 1'b0;
      end
    end else if (fire) begin
      unique case (op)
        OP_LOAD: begin
          op_busy_q <= 1'b1;
          rww_q     <= 1'b0;
        end
        OP_ERASE, OP_WRITE: begin
          op_busy_q <= 1'b1;
          if (z_nrww) halt_q <= 1'b1;
          else        rww_q  <= 1'b1;
        end
        OP_LOCK: op_busy_q <= 1'b1;
        OP_REEN: begin
          rww_q <= 1'b0;
          en_q  <= 1'b0;
          cmd_q <= '0;
        end
        default: ;
      endcase
    end else if (wr_ok) begin
      en_q  <= csr_wdata[B_EN];
      cmd_q <= csr_wdata[B_EN] ? cmd_w : '0;
    end else if (expire) begin
      en_q  <= 1'b0;
      cmd_q <= '0;
    end
  end

  // Command pulses and captured operands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_erase  <= 1'b0;
      cmd_write  <= 1'b0;
      cmd_lock   <= 1'b0;
      cmd_load   <= 1'b0;
      buf_abort  <= 1'b0;
      page_addr  <= '0;
      load_addr  <= '0;
      load_data  <= '0;
      lock_wdata <= '0;
    end else begin
      cmd_erase <= fire && (op == OP_ERASE);
      cmd_write <= fire && (op == OP_WRITE);
      cmd_lock  <= fire && (op == OP_LOCK);
      cmd_load  <= fire && (op == OP_LOAD);
      buf_abort <= wr_ok && csr_wdata[B_EN] && cmd_w.rre && buf_filling;
      if (fire && (op == OP_ERASE || op == OP_WRITE)) page_addr <= z_page;
      if (fire && op == OP_LOAD) begin
        load_addr <= zptr;
        load_data <= {r1, r0};
      end
      if (fire && op == OP_LOCK) lock_wdata <= r0;
    end
  end

  assign rww_blocked = rww_q;
  assign halt_req    = halt_q;
  assign csr_rdata   = {1'b0, rww_q, 1'b0, cmd_q.rre, cmd_q.lck,
                        cmd_q.wr, cmd_q.ers, en_q};
endmodule

// File: rtl/selfprog_ctl_chk.sv
module selfprog_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] csr_rdata,
  input logic       st_strobe,
  input logic       ld_strobe,
  input logic       cmd_erase,
  input logic       cmd_write,
  input logic       cmd_lock,
  input logic       cmd_load,
  input logic       rww_blocked,
  input logic       halt_req,
  input logic       rd_valid
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[5] == 1'b0) && (csr_rdata[7] == 1'b0));

  a_r2_pulse_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_erase || cmd_write || cmd_lock || cmd_load) |-> csr_rdata[0]);

  a_r4_single_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_erase, cmd_write, cmd_lock, cmd_load}));

  a_r4_erase_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_erase |=> !cmd_erase);

  a_r4_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |=> !cmd_write);

  a_r5_halt_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> csr_rdata[0]);

  a_r5_busy_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rww_blocked) |-> $past(st_strobe));

  a_r7_read_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(ld_strobe));

  a_r9_load_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> !rww_blocked);
endmodule

bind selfprog_ctl selfprog_ctl_chk u_chk (.*);

// File: tb/tb_selfprog_ctl.sv
module tb_selfprog_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        st_strobe = 1'b0, ld_strobe = 1'b0;
  logic [15:0] zptr = '0;
  logic [7:0]  r0 = '0, r1 = '0;
  logic        flash_done = 1'b0, buf_filling = 1'b0;
  logic [7:0]  lock_bits = 8'hA5, fuse_bits = 8'h3C;
  logic        cmd_erase, cmd_write, cmd_lock, cmd_load;
  logic [8:0]  page_addr;
  logic [15:0] load_addr, load_data;
  logic [7:0]  lock_wdata, rd_data;
  logic        rww_blocked, halt_req, buf_abort, rd_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_rww = 0;

  always #4 clk = ~clk;

  selfprog_ctl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] v);
    csr_we = 1'b1; csr_wdata = v; tick(); csr_we = 1'b0;
  endtask

  task automatic strobe();
    st_strobe = 1'b1; tick(); st_strobe = 1'b0;
  endtask

  task automatic finish_op();
    tick(); tick();
    flash_done = 1'b1; tick(); flash_done = 1'b0;
  endtask

  function automatic logic [3:0] pulses();
    return {cmd_erase, cmd_write, cmd_lock, cmd_load};
  endfunction

  function automatic bit is_nrww(input logic [15:0] z);
    return z[15:7] >= 9'd448;
  endfunction

  function automatic logic [7:0] code_of(input int op);
    case (op)
      0: return 8'h01;
      1: return 8'h03;
      2: return 8'h05;
      3: return 8'h09;
      default: return 8'h11;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("R1 reset value", csr_rdata, 8'h00);
    chk("R1 reset outputs", {pulses(), halt_req, rww_blocked, rd_valid, buf_abort}, 0);

    // R7: lock/fuse read window
    wr(8'h09);
    chk("R1 lock armed read", csr_rdata, 8'h09);
    zptr = 16'h0000; ld_strobe = 1'b1; tick(); ld_strobe = 1'b0;
    chk("R7 lock read valid", rd_valid, 1);
    chk("R7 lock read data", rd_data, lock_bits);
    zptr = 16'h0001; ld_strobe = 1'b1; tick(); ld_strobe = 1'b0;
    chk("R7 fuse read data", {rd_valid, rd_data}, {1'b1, fuse_bits});
    ld_strobe = 1'b1; tick(); ld_strobe = 1'b0;
    chk("R7 third cycle read", rd_valid, 1);
    ld_strobe = 1'b1; tick(); ld_strobe = 1'b0;
    chk("R7 late read ignored", rd_valid, 0);
    chk("R2 expiry clears", csr_rdata[4:0], 0);
    strobe();
    chk("R2 strobe after expiry", pulses(), 0);

    // R3: illegal writes
    wr(8'h07);
    chk("R3 multi-bit ignored", csr_rdata, 8'h00);
    strobe();
    chk("R3 multi-bit no pulse", pulses(), 0);
    wr(8'h04);
    chk("R3 no enable", csr_rdata[4:0], 0);
    strobe();
    chk("R3 no enable no pulse", pulses(), 0);

    // R10/R8: write while busy, then re-enable
    zptr = 16'h0080; wr(8'h03); strobe();
    chk("R4 erase pulse", pulses(), 4'b1000);
    chk("R5 rww busy set", rww_blocked, 1);
    wr(8'h11); strobe();
    chk("R10 write ignored when busy", csr_rdata, 8'h43);
    chk("R10 busy kept", rww_blocked, 1);
    flash_done = 1'b1; tick(); flash_done = 1'b0;
    chk("R4 done clears", csr_rdata, 8'h40);
    wr(8'h11); strobe();
    chk("R8 re-enable clears", csr_rdata, 8'h00);
    chk("R8 no pulse", pulses(), 0);

    // R11: abort of buffer load
    buf_filling = 1'b1; wr(8'h11);
    chk("R11 abort pulse", buf_abort, 1);
    tick();
    chk("R11 abort one cycle", buf_abort, 0);
    repeat (4) tick();
    wr(8'h01);
    chk("R11 no abort on load arm", buf_abort, 0);
    buf_filling = 1'b0;
    repeat (5) tick();
    exp_rww = 0;

    // Random trials
    for (int t = 0; t < 60; t++) begin
      int op, d;
      logic [15:0] z;
      bit acc;
      op = int'($urandom % 5);
      d  = 1 + int'($urandom % 6);
      z  = 16'($urandom);
      if ($urandom % 2 == 1) z[15:13] = 3'b111; else z[15] = 1'b0;
      zptr = z; r0 = 8'($urandom); r1 = 8'($urandom);
      acc = (d <= 4);
      wr(code_of(op));
      repeat (d - 1) tick();
      strobe();
      if (!acc) begin
        chk("R2 late strobe no pulse", pulses(), 0);
        chk("R2 late strobe cleared", csr_rdata[4:0], 0);
        continue;
      end
      case (op)
        0: begin
          chk("R9 load pulse", pulses(), 4'b0001);
          chk("R9 load addr", load_addr, z);
          chk("R9 load data", load_data, {r1, r0});
          exp_rww = 0;
        end
        1, 2: begin
          chk("R4 pulse kind", pulses(), (op == 1) ? 4'b1000 : 4'b0100);
          chk("R4 page addr", page_addr, z[15:7]);
          if (!is_nrww(z)) exp_rww = 1;
          chk("R5 halt", halt_req, is_nrww(z));
        end
        3: begin
          chk("R6 lock pulse", pulses(), 4'b0010);
          chk("R6 lock data", lock_wdata, r0);
        end
        default: begin
          chk("R8 re-enable no pulse", pulses(), 0);
          exp_rww = 0;
        end
      endcase
      chk("R5 section busy", rww_blocked, exp_rww);
      if (op != 4) begin
        chk("R4 enable held", csr_rdata[0], 1);
        finish_op();
        chk("R4 cleared after done", csr_rdata[4:0], 0);
        chk("R5 halt released", halt_req, 0);
      end else begin
        chk("R8 bits cleared", csr_rdata[4:0], 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule